// File: doc/BRIEF.md
# Selectable-Order Dither Shaper

This block generates a signed pseudo-random word for the least significant bits of the fraction path of a multi-stage noise-shaping modulator. Adding it breaks up limit cycles and spreads the idle tones that a constant fraction input would otherwise produce. The random source is a single bit drawn from a 23-bit maximal-length shift register. That bit can be passed on as it is, or as its first, second or third discrete-time difference, which pushes the dither energy toward high frequencies. A gain shift then scales the chosen word. The dither can also be switched off.

The word is sign-extended to the modulator datapath width, 22 bits by default, and leaves through a register. Mode and gain are sampled on each clock. When the mode code changes, the difference history is cleared, so the first shaped sample after the switch starts from zero history and no stale step appears. The asynchronous reset is active low and its release is synchronised inside the block.

Top module: `dither_shaper`

## Requirements
- R1: While `rst_n` is low, and for the first two rising edges after it rises, `dither_o` is 0.
- R2: Mode codes 0, 5, 6 and 7 switch the dither off: the word registered on that edge is 0.
- R3: Mode code 1 outputs the raw bit b (0 or 1), shifted left by the gain. b is bit 22 (the MSB) of a 23-bit state. The state loads `SEED` in reset and then shifts one place toward the MSB on each active edge, with new LSB = state[22] XOR state[17]. The state is never all zero.
- R4: Mode code 2 outputs d1[n] = b[n] - b[n-1].
- R5: Mode code 3 outputs d2[n] = d1[n] - d1[n-1].
- R6: Mode code 4 outputs d3[n] = d2[n] - d2[n-1], so the output magnitude never exceeds 4 shifted by 7, which is 512.
- R7: `gain_i` (0 to 7) shifts the selected signed value left by that many places, and the result is sign-extended to `DW` bits.
- R8: `dither_o` is registered: the value present after a rising edge is computed from `mode_i`, `gain_i` and the generator state at that edge.
- R9: On any edge where `mode_i` differs from the code taken on the previous active edge, all history samples b[n-1], d1[n-1] and d2[n-1] are treated as 0. The generator and history advance on every active edge in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| mode_i | input | 3 | Shape code: 0 off, 1 raw, 2/3/4 first/second/third difference, 5-7 off |
| gain_i | input | 3 | Left-shift amount applied to the selected value |
| dither_o | output | DW (22) | Signed dither word, two's complement |

## Verification
The bench builds the block with the default 22-bit width and 3-bit gain, and with a seed that differs from the default. This makes every shift from 0 to 7 and the extreme third-difference values of plus and minus 4 times 128 reachable within a few thousand cycles. It also makes it visible whether the seed parameter is honoured. A run of cycle-by-cycle mode switches among the difference orders puts the history clearing on nearly every edge. A long mixed run with random mode and gain codes covers the off codes 5 to 7 and the one-cycle output latency against the reference.

// File: rtl/dsh_pkg.sv
package dsh_pkg;
  localparam int MODE_W = 3;
  localparam int ORDERS = 3;

  typedef enum logic [MODE_W-1:0] {
    SHP_OFF  = 3'd0,
    SHP_RAW  = 3'd1,
    SHP_D1   = 3'd2,
    SHP_D2   = 3'd3,
    SHP_D3   = 3'd4
  } shape_e;
endpackage

// File: rtl/dsh_rst_sync.sv
module dsh_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/dsh_lfsr.sv
module dsh_lfsr #(
  parameter int          W     = 23,
  parameter int          TAP_A = 23,
  parameter int          TAP_B = 18,
  parameter logic [22:0] SEED  = 23'h3A5C7E
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic         bit_o,
  output logic [W-1:0] state_o
);
  localparam logic [W-1:0] SEED_W    = W'(SEED);
  localparam logic [W-1:0] SEED_SAFE = (SEED_W == '0) ? W'(1) : SEED_W;

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb = state_q[TAP_A-1] ^ state_q[TAP_B-1];
    if (state_q == '0) begin
      state_d = SEED_SAFE;
    end else begin
      state_d = {state_q[W-2:0], fb};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED_SAFE;
    end else begin
      state_q <= state_d;
    end
  end

  assign bit_o   = state_q[W-1];
  assign state_o = state_q;
endmodule

// File: rtl/dsh_diff_chain.sv
module dsh_diff_chain #(
  parameter int ORDERS = 3,
  parameter int SW     = ORDERS + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic signed [SW-1:0]       x_i,
  output logic [ORDERS:0][SW-1:0]    tap_o
);
  logic signed [SW-1:0] tap    [0:ORDERS];
  logic signed [SW-1:0] hist_q [0:ORDERS-1];
  logic signed [SW-1:0] hist_d [0:ORDERS-1];

  assign tap[0] = x_i;

  for (genvar k = 0; k < ORDERS; k++) begin : g_stage
    logic signed [SW-1:0] prev_eff;
    assign prev_eff   = clr_i ? '0 : hist_q[k];
    assign tap[k+1]   = tap[k] - prev_eff;
    assign hist_d[k]  = tap[k];
  end

  for (genvar k = 0; k <= ORDERS; k++) begin : g_out
    assign tap_o[k] = tap[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ORDERS; k++) hist_q[k] <= '0;
    end else begin
      for (int k = 0; k < ORDERS; k++) hist_q[k] <= hist_d[k];
    end
  end
endmodule

// File: rtl/dither_shaper.sv
module dither_shaper
  import dsh_pkg::*;
#(
  parameter int          DW     = 22,
  parameter int          GAIN_W = 3,
  parameter int          LFSR_W = 23,
  parameter int          TAP_A  = 23,
  parameter int          TAP_B  = 18,
  parameter logic [22:0] SEED   = 23'h3A5C7E
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [DW-1:0]     dither_o
);
  localparam int SW = ORDERS + 1;

  logic                    rst_sync_n;
  logic                    lfsr_bit;
  logic [LFSR_W-1:0]       lfsr_state;
  logic [MODE_W-1:0]       mode_q;
  logic                    mode_chg;
  logic [ORDERS:0][SW-1:0] taps;
  logic signed [SW-1:0]    sel;
  logic [DW-1:0]           ext;
  logic [DW-1:0]           dither_d;
  logic [DW-1:0]           dither_q;

  dsh_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  dsh_lfsr #(
    .W     (LFSR_W),
    .TAP_A (TAP_A),
    .TAP_B (TAP_B),
    .SEED  (SEED)
  ) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .bit_o   (lfsr_bit),
    .state_o (lfsr_state)
  );

  assign mode_chg = (mode_i != mode_q);

  dsh_diff_chain #(
    .ORDERS (ORDERS),
    .SW     (SW)
  ) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .clr_i  (mode_chg),
    .x_i    ({{(SW-1){1'b0}}, lfsr_bit}),
    .tap_o  (taps)
  );

  always_comb begin
    case (mode_i)
      SHP_RAW: sel = taps[0];
      SHP_D1:  sel = taps[1];
      SHP_D2:  sel = taps[2];
      SHP_D3:  sel = taps[3];
      default: sel = '0;
    endcase
    ext      = {{(DW-SW){sel[SW-1]}}, sel};
    dither_d = ext << gain_i;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q   <= '0;
      dither_q <= '0;
    end else begin
      mode_q   <= mode_i;
      dither_q <= dither_d;
    end
  end

  assign dither_o = dither_q;
endmodule

// File: rtl/dither_shaper_chk.sv
module dither_shaper_chk #(
  parameter int DW     = 22,
  parameter int GAIN_W = 3,
  parameter int LFSR_W = 23
) (
  input logic              clk_i,
  input logic              rst_int_n,
  input logic [2:0]        mode_i,
  input logic [2:0]        mode_q,
  input logic [GAIN_W-1:0] gain_i,
  input logic              lfsr_bit,
  input logic [LFSR_W-1:0] lfsr_state,
  input logic [DW-1:0]     dither_o
);
  localparam int BOUND = 4 << ((1 << GAIN_W) - 1);

  logic [DW-1:0] bit_ext;
  assign bit_ext = {{(DW-1){1'b0}}, lfsr_bit};

  // R1: output held at zero while the internal reset is active
  always @(posedge clk_i) begin
    if (!rst_int_n) begin
      a_r1_reset_zero: assert (dither_o == '0);
    end
  end

  // R2: off codes give a zero word on the next cycle
  a_r2_off_zero: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (mode_i == 3'd0 || mode_i > 3'd4) |=> (dither_o == '0));

  // R3: generator never sits in the all-zero state
  a_r3_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    lfsr_state != '0);

  // R6: magnitude bound of the shaped word
  a_r6_bound: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    ($signed(dither_o) <= BOUND) && ($signed(dither_o) >= -BOUND));

  // R9: first-difference sample after a mode switch equals the raw bit
  a_r9_clear_history: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (mode_i == 3'd2 && mode_q != 3'd2) |=> (dither_o == ($past(bit_ext) << $past(gain_i))));
endmodule

bind dither_shaper dither_shaper_chk #(
  .DW     (DW),
  .GAIN_W (GAIN_W),
  .LFSR_W (LFSR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_int_n  (rst_sync_n),
  .mode_i     (mode_i),
  .mode_q     (mode_q),
  .gain_i     (gain_i),
  .lfsr_bit   (lfsr_bit),
  .lfsr_state (lfsr_state),
  .dither_o   (dither_o)
);

// File: tb/dither_shaper_test.sv
`timescale 1ns/1ps
module dither_shaper_test;
  localparam int          DW   = 22;
  localparam logic [22:0] SEED = 23'h2C0F35;

  logic          clk_i = 1'b0;
  logic          rst_n;
  logic [2:0]    mode_i;
  logic [2:0]    gain_i;
  logic [DW-1:0] dither_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit started  = 0;
  bit done     = 0;
  string tag   = "R1";

  always #2.5 clk_i = ~clk_i;

  dither_shaper #(.DW(DW), .SEED(SEED)) uut (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .gain_i   (gain_i),
    .dither_o (dither_o)
  );

  // behavioural reference
  int            sync_cnt;
  int unsigned   gen;
  int            hist[$];
  int            prev_mode;
  logic [DW-1:0] expv;

  function automatic int at(int k);
    return (k < hist.size()) ? hist[k] : 0;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_n) begin
      sync_cnt  = 0;
      gen       = SEED;
      hist.delete();
      prev_mode = 0;
      expv      = '0;
    end else if (sync_cnt < 2) begin
      sync_cnt++;
      expv = '0;
    end else begin
      int b, v, fb;
      b = (gen >> 22) & 1;
      if (int'(mode_i) != prev_mode) hist.delete();
      prev_mode = int'(mode_i);
      hist.push_front(b);
      if (hist.size() > 4) void'(hist.pop_back());
      case (mode_i)
        3'd1:    v = at(0);
        3'd2:    v = at(0) - at(1);
        3'd3:    v = at(0) - 2*at(1) + at(2);
        3'd4:    v = at(0) - 3*at(1) + 3*at(2) - at(3);
        default: v = 0;
      endcase
      expv = DW'(v * (1 << gain_i));
      fb  = int'(((gen >> 22) ^ (gen >> 17)) & 1);
      gen = ((gen << 1) | fb) & 32'h7FFFFF;
    end
  end

  always @(negedge clk_i) begin
    if (started && !done) begin
      n_checks++;
      if (dither_o !== expv) begin
        n_fail++;
        $display("FAIL %s: dither_o actual %0d expected %0d (mode %0d gain %0d)",
                 tag, $signed(dither_o), $signed(expv), mode_i, gain_i);
      end
    end
  end

  task automatic run(input logic [2:0] m, input logic [2:0] g, input int n, input string t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      mode_i = m;
      gain_i = g;
      tag    = t;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: run did not complete (all requirements) actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned lcg;
    rst_n  = 1'b0;
    mode_i = 3'd1;
    gain_i = 3'd2;
    tag    = "R1";
    started = 1;
    repeat (5) @(negedge clk_i);
    rst_n = 1'b1;
    run(3'd1, 3'd2, 3, "R1");
    run(3'd1, 3'd0, 60, "R3");
    run(3'd1, 3'd3, 40, "R7");
    run(3'd2, 3'd0, 50, "R4");
    run(3'd3, 3'd0, 50, "R5");
    run(3'd4, 3'd0, 50, "R6");
    run(3'd4, 3'd7, 200, "R6");
    run(3'd3, 3'd7, 40, "R7");
    run(3'd0, 3'd5, 30, "R2");
    run(3'd5, 3'd4, 20, "R2");
    run(3'd6, 3'd1, 20, "R2");
    run(3'd7, 3'd7, 20, "R2");
    for (int i = 0; i < 300; i++) begin
      run(3'(2 + (i % 3)), 3'(i % 8), 1, "R9");
    end
    for (int i = 0; i < 100; i++) begin
      run(3'd2, 3'd1, 1 + (i % 4), "R9");
      run(3'd4, 3'd1, 1 + (i % 3), "R9");
    end
    lcg = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      lcg = lcg * 1103515245 + 12345;
      run(3'(lcg >> 16), 3'(lcg >> 24), 1 + int'((lcg >> 8) & 3), "R8");
    end
    @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule